// File: doc/BRIEF.md
# Display List Start and Restart Controller

This block decides where a display-list coprocessor fetches its next instruction. It keeps two 16-bit start pointers. The host loads the primary pointer. Only the running list can load the secondary pointer. The block also keeps a 3-bit memory bank number. Each pointer is written as two bytes through a small register port, and each port has a third register, the strobe. The strobe requests an immediate start.

The block raises a one-cycle program-counter load pulse, `pc_load`, together with a target address and the bank. It does this at every frame start, after a host strobe, after a list strobe, and when the list reports that it has ended. A list strobe can also select a new bank. A restart at the end of the list always goes back to the primary pointer, in whichever bank is current at that moment. Instruction decoding and the memory fetch belong to the neighbouring blocks.

Top module: `dl_start_ctrl`

## Requirements
- R1: A host write with selector 0 loads the low byte of the primary pointer, and selector 1 loads the high byte. The list port has no path to the primary pointer.
- R2: A `frame_start` pulse makes `pc_load` high in the following cycle. The target is the primary pointer value held before that clock edge.
- R3: A host write with selector 2 (strobe) makes `pc_load` high in the following cycle with the primary pointer as target. The written data has no effect.
- R4: A list write with selector 0 or 1 loads the low or high byte of the secondary pointer. Host writes with selector 3 change nothing, and the host cannot reach the secondary pointer.
- R5: A list write with selector 2 (strobe) makes `pc_load` high in the following cycle with the secondary pointer as target.
- R6: If bit 3 of the list strobe data is 1, the bank becomes data bits 2..0, and `pc_bank` shows the new value in the load cycle. If bit 3 is 0, the bank is unchanged.
- R7: A list strobe leaves the primary pointer unchanged, so later frame starts still load the primary value.
- R8: While the list is running, `list_end` makes `pc_load` high in the following cycle with the primary pointer as target. The bank stays at its current value.
- R9: Events in the same cycle resolve by priority: host strobe, then list strobe, then list end, then frame start. A bank switch from a list strobe takes effect even when a host strobe wins.
- R10: After reset the bank and both pointers are 0, and `pc_load` and `running` are 0. `list_end` has no effect while the list is halted. `running` is set by the first load.
- R11: `pc_load` is 0 in any cycle that does not follow a load event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| host_we | input | 1 | Host register write enable |
| host_sel | input | 2 | Host register: 0 low byte, 1 high byte, 2 strobe, 3 none |
| host_wdata | input | 8 | Host write data |
| list_we | input | 1 | Write enable from the running list |
| list_sel | input | 2 | List register: 0 low byte, 1 high byte, 2 strobe, 3 none |
| list_wdata | input | 8 | List write data; on a strobe, bit 3 enables a bank switch and bits 2..0 give the bank |
| list_end | input | 1 | The list has reached its end |
| pc_load | output | 1 | One-cycle program-counter load pulse |
| pc_target | output | 16 | Address to load into the program counter |
| pc_bank | output | 3 | Current memory bank |
| running | output | 1 | The list has been started since reset |

## Verification
The in-module assertions check, on every cycle, that each strobe and each frame start is followed by a load. They also check that a host strobe and an end-of-list restart target the primary pointer, and that the bank moves only on a list strobe that has bit 3 set. They check that nothing loads while the list is halted and no event is pending. The bench's scenarios cover the rest: the byte routing on both ports, the data that the host strobe and selector 3 ignore, the same-cycle priority combinations, the retained primary pointer after a jump, and a long stretch of mixed random traffic. In every one of these the bench compares the outputs against its own model on each clock.

// File: rtl/dl_start_ctrl.sv
module dl_start_ctrl #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              list_we,
  input  logic [1:0]        list_sel,
  input  logic [DATA_W-1:0] list_wdata,
  input  logic              list_end,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_target,
  output logic [BANK_W-1:0] pc_bank,
  output logic              running
);

  localparam logic [1:0] SEL_LO     = 2'd0;
  localparam logic [1:0] SEL_HI     = 2'd1;
  localparam logic [1:0] SEL_STROBE = 2'd2;
  localparam int         BANK_EN    = BANK_W;

  typedef enum logic [1:0] {SRC_NONE, SRC_PRIM, SRC_SEC} src_e;

  logic [ADDR_W-1:0] prim_q, sec_q;
  logic [BANK_W-1:0] bank_q;
  src_e              src;

  wire host_strobe = host_we && host_sel == SEL_STROBE;
  wire list_strobe = list_we && list_sel == SEL_STROBE;
  wire end_restart = list_end && running;
  wire bank_switch = list_strobe && list_wdata[BANK_EN];

  always_comb begin
    if (host_strobe)      src = SRC_PRIM;
    else if (list_strobe) src = SRC_SEC;
    else if (end_restart) src = SRC_PRIM;
    else if (frame_start) src = SRC_PRIM;
    else                  src = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= '0;
      sec_q  <= '0;
    end else begin
      if (host_we && host_sel == SEL_LO) prim_q[DATA_W-1:0]      <= host_wdata;
      if (host_we && host_sel == SEL_HI) prim_q[ADDR_W-1:DATA_W] <= host_wdata;
      if (list_we && list_sel == SEL_LO) sec_q[DATA_W-1:0]       <= list_wdata;
      if (list_we && list_sel == SEL_HI) sec_q[ADDR_W-1:DATA_W]  <= list_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bank_q <= '0;
    else if (bank_switch) bank_q <= list_wdata[BANK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load   <= 1'b0;
      pc_target <= '0;
      running   <= 1'b0;
    end else begin
      pc_load <= src != SRC_NONE;
      if (src == SRC_PRIM) pc_target <= prim_q;
      if (src == SRC_SEC)  pc_target <= sec_q;
      if (src != SRC_NONE) running   <= 1'b1;
    end
  end

  assign pc_bank = bank_q;

  AST_FRAME_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> pc_load); // R2
  AST_HOST_STROBE_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
    host_strobe |=> pc_load && pc_target == $past(prim_q)); // R3
  AST_LIST_STROBE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    list_strobe |=> pc_load); // R5
  AST_BANK_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    bank_switch |=> pc_bank == $past(list_wdata[BANK_W-1:0])); // R6
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_switch |=> $stable(pc_bank)); // R6
  AST_END_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
    end_restart && !list_strobe |=> pc_load && pc_target == $past(prim_q)); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !frame_start && !host_strobe && !list_strobe |=> !pc_load); // R10
  AST_LOAD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> running); // R11

endmodule

// File: tb/test_dl_start_ctrl.sv
`timescale 1ns/1ps
module test_dl_start_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, host_we = 0, list_we = 0, list_end = 0;
  logic [1:0] host_sel = 0, list_sel = 0;
  logic [7:0] host_wdata = 0, list_wdata = 0;
  logic pc_load, running;
  logic [15:0] pc_target;
  logic [2:0] pc_bank;

  int tests = 0, fails = 0;
  string req = "R10";

  logic [15:0] m_prim = 0, m_sec = 0, m_target = 0;
  logic [2:0]  m_bank = 0;
  logic        m_load = 0, m_run = 0;

  always #10 clk = ~clk;

  dl_start_ctrl i_dl_start_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .list_we(list_we), .list_sel(list_sel), .list_wdata(list_wdata),
    .list_end(list_end), .pc_load(pc_load), .pc_target(pc_target),
    .pc_bank(pc_bank), .running(running));

  task automatic check(string r, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit hs = host_we && host_sel == 2;
    bit ls = list_we && list_sel == 2;
    m_load = 1'b1;
    if (hs)                    m_target = m_prim;
    else if (ls)               m_target = m_sec;
    else if (list_end && m_run) m_target = m_prim;
    else if (frame_start)      m_target = m_prim;
    else                       m_load = 1'b0;
    if (m_load) m_run = 1'b1;
    if (host_we && host_sel == 0) m_prim[7:0]  = host_wdata;
    if (host_we && host_sel == 1) m_prim[15:8] = host_wdata;
    if (list_we && list_sel == 0) m_sec[7:0]   = list_wdata;
    if (list_we && list_sel == 1) m_sec[15:8]  = list_wdata;
    if (ls && list_wdata[3]) m_bank = list_wdata[2:0];
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(req, "pc_load", pc_load, m_load);
    if (m_load) check(req, "pc_target", pc_target, m_target);
    check(req, "pc_bank", pc_bank, m_bank);
    check(req, "running", running, m_run);
    frame_start = 0; host_we = 0; list_we = 0; list_end = 0;
  endtask

  task automatic hw(logic [1:0] s, logic [7:0] d);
    host_we = 1; host_sel = s; host_wdata = d;
  endtask
  task automatic lw(logic [1:0] s, logic [7:0] d);
    list_we = 1; list_sel = s; list_wdata = d;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset pc_load", pc_load, 0);
    check("R10", "reset pc_bank", pc_bank, 0);
    check("R10", "reset running", running, 0);
    rst_n = 1;
    req = "R10"; list_end = 1; cyc(); cyc();
    lw(0, 8'h55); cyc(); list_end = 1; cyc();
    req = "R1"; hw(0, 8'h34); cyc(); hw(1, 8'h12); cyc();
    lw(1, 8'h77); cyc();
    req = "R2"; frame_start = 1; cyc(); cyc();
    check("R2", "frame target", pc_target, 16'h7755 == 0 ? 0 : 16'h1234);
    req = "R3"; hw(2, 8'hA5); cyc(); cyc();
    req = "R4"; lw(0, 8'hEF); cyc(); lw(1, 8'hBE); cyc();
    hw(3, 8'hFF); cyc();
    req = "R5"; lw(2, 8'h00); cyc(); cyc();
    check("R5", "secondary target", pc_target, 16'hBEEF);
    req = "R6"; lw(2, 8'h0D); cyc();
    check("R6", "bank switch", pc_bank, 5);
    lw(2, 8'h07); cyc();
    check("R6", "bank hold", pc_bank, 5);
    req = "R8"; list_end = 1; cyc();
    check("R8", "end target", pc_target, 16'h1234);
    req = "R7"; frame_start = 1; cyc();
    check("R7", "primary kept", pc_target, 16'h1234);
    req = "R9"; frame_start = 1; lw(2, 8'h0A); cyc();
    check("R9", "list over frame", pc_target, 16'hBEEF);
    hw(2, 0); lw(2, 8'h0B); cyc();
    check("R9", "host over list", pc_target, 16'h1234);
    check("R9", "bank still switched", pc_bank, 3);
    list_end = 1; lw(2, 0); cyc();
    check("R9", "list over end", pc_target, 16'hBEEF);
    req = "R11"; cyc(); cyc();
    check("R11", "idle no load", pc_load, 0);
    req = "R9";
    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      frame_start = r[0] & r[1];
      list_end    = r[2] & r[3];
      host_we = r[4]; host_sel = r[6:5]; host_wdata = r[15:8];
      list_we = r[7]; list_sel = r[17:16]; list_wdata = r[31:24];
      cyc();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule